// File: doc/BRIEF.md
# Multi-Line Delay Buffer

This block supplies the vertical taps of a line-based image filter. A registered input sample enters a chain of seven programmable delay lines of 12-bit samples. Each line delays its input by one video line, so the eight tap outputs hold the same column position on eight consecutive lines. One 12-bit configuration value sets the line length for every line at once.

The lines can be run as a plain delay chain. They can also be switched to recirculate, where each line replays its own contents, or to a preload mode in which all lines fill from the input register together. A cascade trim removes two cycles from the first line, so that a second instance fed from the cascade output of the first one keeps the line alignment. An eighth line serves field filtering. It either extends the chain or delays the samples of a separate field input port. An active-low shift enable freezes every register and every line. The memories are inferred arrays addressed by one circular pointer per line.

Top module: `mlb_top`

## Requirements
- R1: The length of every line is min(cfg_len, MAX_CFG) + 4 shifts, where MAX_CFG is a parameter (60 by default, 3072 for full-size lines). A larger value acts as MAX_CFG.
- R2: With recirc=0 and par_load=0, line k (k = 1..7, tap slot k) outputs the output of line k-1 delayed by one line length. For line 1 the source is slot 0.
- R3: Slot 0 of taps_o (bits 11:0) is the input register. It takes din on every shift edge and is cleared by reset. Tap slot k occupies bits 12k+11 : 12k.
- R4: With recirc=1, each line (including the field line) writes its own output back, so its output repeats with a period of its own length. Recirculation overrides par_load and the field port selection.
- R5: With par_load=1 and recirc=0, all seven lines take the input register as their input, so each one fills in a single line time.
- R6: With casc_mode=1 the first line is two shifts shorter than the others. With casc_mode=0 all lines have the same length.
- R7: While shift_n=1, the input registers, the cascade output, the line contents and the line outputs do not change, whatever din and fld_din do.
- R8: cout_o is a register that takes the output of line 7 on each shift edge and is cleared by reset.
- R9: The field line has the common length and drives fld_tap_o. With fld_en=0 its input is the output of line 7. With fld_en=1 its input is a register loaded from fld_din on each shift edge. The cascade trim does not apply to it.
- R10: A change of line length restarts the line pointers. Once every line has been fed a full line since the change, all taps again follow R2 with the new length, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_n | input | 1 | Shift enable, active low |
| cfg_len | input | 12 | Line length minus 4 |
| recirc | input | 1 | 1: lines replay their contents |
| par_load | input | 1 | 1: all lines load from the input register |
| casc_mode | input | 1 | 1: shorten the first line by two shifts |
| fld_en | input | 1 | 1: field line fed from the field port |
| din | input | 12 | Sample input |
| fld_din | input | 12 | Field sample input |
| taps_o | output | 96 | Eight taps, slot 0 is the input register |
| fld_tap_o | output | 12 | Field line output |
| cout_o | output | 12 | Registered output of the last line, for cascading |

## Verification
The hardest state to reach is recirculation of lines whose contents are known and whose lengths differ. Each line has to be full and at a known pointer phase, while the first line is trimmed and the field line holds data from its own port. The bench reaches this state from the ports. It resets, selects a short length with the cascade trim, preloads all lines and the field line at once, then switches to recirculation. It then drives unrelated input values and checks that each tap repeats its own history with its own period. A length change without a reset is covered by reprogramming after the clamped-length cases and refilling.

// File: rtl/mlb_pkg.sv
`timescale 1ns/1ps
package mlb_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int CFG_W     = 12;
    localparam int BASE_LEN  = 4;
    localparam int CASC_TRIM = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CFG_W-1:0]    cfg_t;

    typedef enum logic [1:0] {
        SRC_CHAIN = 2'd0,
        SRC_SELF  = 2'd1,
        SRC_MAIN  = 2'd2,
        SRC_FIELD = 2'd3
    } src_e;

    typedef struct packed {
        logic recirc;
        logic par_load;
        logic fld_en;
    } mode_t;

    // Recirculation wins, then the field port (field line only), then preload.
    function automatic src_e pick_src(mode_t m, logic is_field);
        if (m.recirc)               return SRC_SELF;
        if (is_field && m.fld_en)   return SRC_FIELD;
        if (m.par_load)             return SRC_MAIN;
        return SRC_CHAIN;
    endfunction

    function automatic sample_t sel_sample(src_e s, sample_t chain, sample_t self_d,
                                           sample_t main_d, sample_t field_d);
        sample_t r;
        case (s)
            SRC_SELF:  r = self_d;
            SRC_MAIN:  r = main_d;
            SRC_FIELD: r = field_d;
            default:   r = chain;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mlb_len_calc.sv
`timescale 1ns/1ps
module mlb_len_calc
    import mlb_pkg::*;
#(
    parameter int MAX_CFG = 60,
    parameter int LEN_W   = 7
) (
    input  cfg_t             cfg_len,
    input  logic             casc_mode,
    output logic [LEN_W-1:0] len_main,
    output logic [LEN_W-1:0] len_first
);
    cfg_t cfg_c;

    always_comb begin
        cfg_c     = (cfg_len > CFG_W'(MAX_CFG)) ? CFG_W'(MAX_CFG) : cfg_len;
        len_main  = LEN_W'(cfg_c) + LEN_W'(BASE_LEN);
        len_first = casc_mode ? (len_main - LEN_W'(CASC_TRIM)) : len_main;
    end
endmodule

// File: rtl/mlb_front.sv
`timescale 1ns/1ps
module mlb_front
    import mlb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    shift,
    input  sample_t din,
    input  sample_t fld_din,
    output sample_t in_q,
    output sample_t fld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            fld_q <= '0;
        end else if (shift) begin
            in_q  <= din;
            fld_q <= fld_din;
        end
    end
endmodule

// File: rtl/mlb_line.sv
`timescale 1ns/1ps
module mlb_line
    import mlb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic [LEN_W-1:0] len,
    input  sample_t          wr_data,
    output sample_t          rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    sample_t          mem [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] last;
    logic [LEN_W-1:0] len_q;
    logic             restart;

    assign restart = (len != len_q);
    assign last    = PTR_W'(len - LEN_W'(1));
    assign rd_data = mem[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            len_q <= '0;
        end else begin
            len_q <= len;
            if (restart)
                ptr <= '0;
            else if (shift)
                ptr <= (ptr == last) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (shift && !rst)
            mem[ptr] <= wr_data;
    end
endmodule

// File: rtl/mlb_top.sv
`timescale 1ns/1ps
module mlb_top
    import mlb_pkg::*;
#(
    parameter int NUM_LINES = 7,
    parameter int MAX_CFG   = 60,
    parameter bit HAS_FIELD = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              shift_n,
    input  logic [CFG_W-1:0]                  cfg_len,
    input  logic                              recirc,
    input  logic                              par_load,
    input  logic                              casc_mode,
    input  logic                              fld_en,
    input  logic [SAMPLE_W-1:0]               din,
    input  logic [SAMPLE_W-1:0]               fld_din,
    output logic [(NUM_LINES+1)*SAMPLE_W-1:0] taps_o,
    output logic [SAMPLE_W-1:0]               fld_tap_o,
    output logic [SAMPLE_W-1:0]               cout_o
);
    localparam int DEPTH = MAX_CFG + BASE_LEN;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic             shift;
    logic [LEN_W-1:0] len_main;
    logic [LEN_W-1:0] len_first;
    sample_t          in_q;
    sample_t          fld_q;
    mode_t            mode;
    src_e             src_line;
    sample_t          chain_in [NUM_LINES+1];
    sample_t          line_out [NUM_LINES];

    assign shift         = !shift_n;
    assign mode.recirc   = recirc;
    assign mode.par_load = par_load;
    assign mode.fld_en   = fld_en;
    assign src_line      = pick_src(mode, 1'b0);
    assign chain_in[0]   = in_q;

    mlb_len_calc #(.MAX_CFG(MAX_CFG), .LEN_W(LEN_W)) u_len (
        .cfg_len   (cfg_len),
        .casc_mode (casc_mode),
        .len_main  (len_main),
        .len_first (len_first)
    );

    mlb_front u_front (
        .clk     (clk),
        .rst     (rst),
        .shift   (shift),
        .din     (din),
        .fld_din (fld_din),
        .in_q    (in_q),
        .fld_q   (fld_q)
    );

    assign taps_o[SAMPLE_W-1:0] = in_q;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        sample_t          wr_d;
        sample_t          rd_d;
        logic [LEN_W-1:0] len_k;

        assign len_k = (k == 0) ? len_first : len_main;
        assign wr_d  = sel_sample(src_line, chain_in[k], rd_d, in_q, in_q);

        mlb_line #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_line (
            .clk     (clk),
            .rst     (rst),
            .shift   (shift),
            .len     (len_k),
            .wr_data (wr_d),
            .rd_data (rd_d)
        );

        assign line_out[k]   = rd_d;
        assign chain_in[k+1] = rd_d;
        assign taps_o[(k+1)*SAMPLE_W +: SAMPLE_W] = rd_d;
    end

    if (HAS_FIELD) begin : g_field
        sample_t fwr_d;
        sample_t frd_d;
        src_e    src_fld;

        assign src_fld = pick_src(mode, 1'b1);
        assign fwr_d   = sel_sample(src_fld, chain_in[NUM_LINES], frd_d, in_q, fld_q);

        mlb_line #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_fline (
            .clk     (clk),
            .rst     (rst),
            .shift   (shift),
            .len     (len_main),
            .wr_data (fwr_d),
            .rd_data (frd_d)
        );

        assign fld_tap_o = frd_d;
    end else begin : g_nofield
        assign fld_tap_o = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cout_o <= '0;
        else if (shift)
            cout_o <= line_out[NUM_LINES-1];
    end
endmodule

// File: rtl/mlb_chk.sv
`timescale 1ns/1ps
module mlb_chk
    import mlb_pkg::*;
#(
    parameter int NUM_LINES = 7,
    parameter int MAX_CFG   = 60,
    parameter int LEN_W     = 7
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              shift_n,
    input logic                              casc_mode,
    input logic [SAMPLE_W-1:0]               din,
    input logic [(NUM_LINES+1)*SAMPLE_W-1:0] taps_o,
    input logic [SAMPLE_W-1:0]               cout_o,
    input logic [LEN_W-1:0]                  len_main,
    input logic [LEN_W-1:0]                  len_first
);
    p_len_range_r1: assert property (@(posedge clk) disable iff (rst)
        (len_main >= LEN_W'(BASE_LEN)) && (len_main <= LEN_W'(MAX_CFG + BASE_LEN)));

    p_first_trim_r6: assert property (@(posedge clk) disable iff (rst)
        casc_mode |-> ((len_first + LEN_W'(2)) == len_main));

    p_first_equal_r6: assert property (@(posedge clk) disable iff (rst)
        !casc_mode |-> (len_first == len_main));

    p_input_reg_r3: assert property (@(posedge clk) disable iff (rst)
        !shift_n |=> (taps_o[SAMPLE_W-1:0] == $past(din)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        shift_n |=> ($stable(cout_o) && $stable(taps_o[SAMPLE_W-1:0])));

    p_cascade_out_r8: assert property (@(posedge clk) disable iff (rst)
        !shift_n |=> (cout_o == $past(taps_o[NUM_LINES*SAMPLE_W +: SAMPLE_W])));
endmodule

bind mlb_top mlb_chk #(
    .NUM_LINES (NUM_LINES),
    .MAX_CFG   (MAX_CFG),
    .LEN_W     (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_n   (shift_n),
    .casc_mode (casc_mode),
    .din       (din),
    .taps_o    (taps_o),
    .cout_o    (cout_o),
    .len_main  (len_main),
    .len_first (len_first)
);

// File: tb/sim_mlb_top.sv
`timescale 1ns/1ps
module sim_mlb_top;
    localparam int NL   = 7;
    localparam int MAXC = 60;
    localparam int W    = 12;
    localparam int NT   = 5;

    // stimulus table: length value, cascade trim, expected common length, expected first length
    localparam int T_CFG  [NT] = '{0, 5, 60, 100, 4095};
    localparam int T_CASC [NT] = '{0, 1, 0, 1, 0};
    localparam int T_LEN  [NT] = '{4, 9, 64, 64, 64};
    localparam int T_LEN1 [NT] = '{4, 7, 64, 62, 64};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              shift_n = 1'b1;
    logic [11:0]       cfg_len = '0;
    logic              recirc = 1'b0;
    logic              par_load = 1'b0;
    logic              casc_mode = 1'b0;
    logic              fld_en = 1'b0;
    logic [11:0]       din = '0;
    logic [11:0]       fld_din = '0;
    logic [(NL+1)*W-1:0] taps_o;
    logic [11:0]       fld_tap_o;
    logic [11:0]       cout_o;

    int n_chk = 0;
    int n_fail = 0;
    int n = 0;
    logic [11:0] h  [4096];
    logic [11:0] hf [4096];

    always #2.5 clk = ~clk;

    mlb_top u0 (
        .clk(clk), .rst(rst), .shift_n(shift_n), .cfg_len(cfg_len),
        .recirc(recirc), .par_load(par_load), .casc_mode(casc_mode),
        .fld_en(fld_en), .din(din), .fld_din(fld_din),
        .taps_o(taps_o), .fld_tap_o(fld_tap_o), .cout_o(cout_o)
    );

    function automatic logic [11:0] tap(input int k);
        return taps_o[k*W +: W];
    endfunction

    function automatic logic [11:0] pat(input int seed, input int i);
        return 12'((seed * 37 + i * 13 + (i * i) % 97) & 12'hFFF);
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // one clock; inputs driven at a falling edge, outputs sampled at the next falling edge
    task automatic step(input bit en, input logic [11:0] v, input logic [11:0] fv);
        shift_n = !en;
        din     = v;
        fld_din = fv;
        @(negedge clk);
        if (en) begin
            n++;
            h[n]  = v;
            hf[n] = fv;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        shift_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        h[0] = '0;
        hf[0] = '0;
    endtask

    task automatic check_chain(input int L, input int L1, input string req);
        chk("R3", tap(0), h[n]);
        for (int k = 1; k <= NL; k++)
            chk((k == 1) ? {req, "/R6"} : req, tap(k), h[n - L1 - (k - 1) * L]);
        chk("R8", cout_o, h[n - 1 - L1 - (NL - 1) * L]);
        chk("R9", fld_tap_o, h[n - L1 - NL * L]);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // reset state of the input register and the cascade register
        chk("R3 reset", tap(0), 12'h000);
        chk("R8 reset", cout_o, 12'h000);

        // table walk: delay chain with several lengths, clamping and trim
        for (int i = 0; i < NT; i++) begin
            do_reset();
            cfg_len   = 12'(T_CFG[i]);
            casc_mode = T_CASC[i][0];
            fld_en    = 1'b0;
            par_load  = 1'b0;
            recirc    = 1'b0;
            for (int j = 0; j < T_LEN1[i] + NL * T_LEN[i] + 8; j++)
                step(1'b1, pat(i + 1, j), 12'h000);
            check_chain(T_LEN[i], T_LEN1[i], (T_CFG[i] > MAXC) ? "R1" : "R2");
        end

        // R10: new length without reset, then refill
        cfg_len   = 12'd1;
        casc_mode = 1'b0;
        for (int j = 0; j < 9 * 5 + 4; j++)
            step(1'b1, pat(11, j), 12'h000);
        check_chain(5, 5, "R10");

        // R5 and R9: parallel preload with the field port, trim on
        do_reset();
        cfg_len   = 12'd2;
        casc_mode = 1'b1;
        par_load  = 1'b1;
        fld_en    = 1'b1;
        for (int j = 0; j < 10; j++)
            step(1'b1, pat(21, j), pat(33, j));
        chk("R5 line1", tap(1), h[n - 4]);
        for (int k = 2; k <= NL; k++)
            chk("R5", tap(k), h[n - 6]);
        chk("R9 field port", fld_tap_o, hf[n - 6]);
        chk("R8 preload", cout_o, h[n - 7]);

        // R4: recirculate, par_load still set, new input values must not enter the lines
        begin
            int n0;
            n0 = n;
            recirc = 1'b1;
            for (int j = 1; j <= 12; j++) begin
                step(1'b1, pat(55, j), pat(77, j));
                chk("R4 line1", tap(1), h[n0 - 4 + (j % 4)]);
                chk("R4", tap(NL), h[n0 - 6 + (j % 6)]);
                chk("R4 field", fld_tap_o, hf[n0 - 6 + (j % 6)]);
            end
            chk("R3 recirc", tap(0), h[n]);
        end

        // R7: hold with changing inputs
        begin
            logic [(NL+1)*W-1:0] snap_t;
            logic [11:0]         snap_c;
            logic [11:0]         snap_f;
            snap_t = taps_o;
            snap_c = cout_o;
            snap_f = fld_tap_o;
            recirc = 1'b0;
            par_load = 1'b0;
            for (int j = 0; j < 6; j++)
                step(1'b0, pat(90, j), pat(91, j));
            for (int k = 0; k <= NL; k++)
                chk("R7", tap(k), snap_t[k*W +: W]);
            chk("R7 cout", cout_o, snap_c);
            chk("R7 field", fld_tap_o, snap_f);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule